// File: doc/BRIEF.md
# SPI Transmit/Receive Byte Queues with DMA Requests

This block sits between a processor bus and an SPI shift engine. Bytes that the processor writes go into a transmit queue. The shift engine takes them one at a time with a load strobe. Bytes that the shift engine completes go into a receive queue with a capture strobe, and the processor takes them with a read strobe. Because the receive side is queued, the shifter can finish a new character while earlier ones still wait to be read.

The receive queue raises an interrupt when its occupancy reaches a programmable threshold. It also records an overrun when a byte arrives while the queue is full. Each direction has an active-high DMA request with an active-high clear input. In single-transfer mode a request means at least one entry or slot is available, which suits a DMA engine that moves one byte between processor cycles. In multi-transfer mode a request means a whole burst of threshold size is available.

Both queues share one depth parameter: 64 by default, with 128, 256 or 512 as options. Register decoding and the shift engine are outside this block.

Top module: `spi_fifo_dma`

## Requirements
- R1: Each queue is DEPTH entries deep (a power of two, default 64) and returns bytes in the order they were accepted. The level outputs report the current occupancy, from 0 to DEPTH.
- R2: While the transmit queue holds DEPTH bytes, a processor write is discarded and the level stays DEPTH. One shifter load frees a slot, and the next write is accepted.
- R3: A capture while the receive queue is full and no read is in the same cycle is discarded, and the stored bytes are kept. `ovr_flag` is high from the following cycle and stays high until `ovr_clr` is pulsed.
- R4: `irq` is high one cycle after the receive level is at or above `trig_level` while `irq_en` is 1. It is low one cycle after either condition goes away.
- R5: With `dma_multi`=0 (single transfer), `rx_dma_req` follows "receive level is not 0" and `tx_dma_req` follows "transmit level is below DEPTH", each one cycle late.
- R6: With `dma_multi`=1 (multi transfer), `rx_dma_req` follows "receive level is at least `trig_level`" and `tx_dma_req` follows "free transmit slots are at least `trig_level`", each one cycle late.
- R7: A one-cycle pulse on a DMA clear input holds that request low for the two cycles after the pulse. After that the request follows its condition again.
- R8: A read and a write in the same cycle on a full queue both take effect and the level stays unchanged. On an empty queue only the write takes effect, and no data is returned.
- R9: While reset is high, both levels are 0 and `irq`, `ovr_flag`, both DMA requests and both data-valid outputs are 0.
- R10: A read of a non-empty queue (a shifter load or a processor read) presents the oldest byte with its valid bit high in the cycle after the strobe. A read of an empty queue leaves the valid bit low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_wr_en | input | 1 | Processor write strobe into the transmit queue |
| cpu_wr_data | input | 8 | Byte written by the processor |
| tx_level | output | $clog2(DEPTH)+1 | Transmit queue occupancy |
| cpu_rd_en | input | 1 | Processor read strobe from the receive queue |
| cpu_rd_data | output | 8 | Byte read by the processor |
| cpu_rd_valid | output | 1 | `cpu_rd_data` holds a byte from the last read |
| rx_level | output | $clog2(DEPTH)+1 | Receive queue occupancy |
| sh_load | input | 1 | Shifter takes the next transmit byte |
| sh_tx_data | output | 8 | Byte handed to the shifter |
| sh_tx_valid | output | 1 | `sh_tx_data` holds a byte from the last load |
| sh_cap | input | 1 | Shifter has completed a received byte |
| sh_cap_data | input | 8 | Completed received byte |
| trig_level | input | $clog2(DEPTH)+1 | Threshold for the interrupt and for multi-transfer requests |
| irq_en | input | 1 | Interrupt enable |
| dma_multi | input | 1 | 0 = single-transfer requests, 1 = multi-transfer requests |
| ovr_clr | input | 1 | Clears the overrun flag |
| ovr_flag | output | 1 | Sticky receive overrun |
| irq | output | 1 | Receive threshold interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_dma_clr | input | 1 | Clear for the transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_dma_clr | input | 1 | Clear for the receive DMA request |

## Verification
The assertions watch, on every cycle, the following:
- the occupancy bounds;
- that a level holds when a write meets a full queue;
- that a read of an empty queue does nothing;
- that a simultaneous read and write on a full queue stays full;
- that overrun is set and is sticky;
- that the interrupt is quiet while disabled;
- that a request is low after its clear.

Only the bench scenarios can show the byte order through each queue, that a discarded byte never comes back out, the exact cycle at which the threshold interrupt and the two request modes switch, and the return of a request once the clear hold-off has ended.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    DMA_SINGLE = 1'b0,
    DMA_MULTI  = 1'b1
  } dma_mode_e;
endpackage

// File: rtl/spi_fifo_core.sv
module spi_fifo_core #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push,
  input  logic [DW-1:0]               wdata,
  input  logic                        pop,
  output logic [DW-1:0]               rdata,
  output logic                        rvalid,
  output logic [$clog2(DEPTH):0]      count,
  output logic                        full,
  output logic                        empty
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          pop_ok, push_ok;

  assign full    = (count == DEPTH_C);
  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);

  // storage without reset so that block RAM can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
    if (pop_ok)  rdata   <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp     <= '0;
      rp     <= '0;
      count  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= pop_ok;
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C); // R1
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop |=> $stable(count)); // R2
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
    full && push && pop |=> full); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
    empty && pop && !push |=> (count == '0) && !rvalid); // R8
endmodule

// File: rtl/spi_dma_req.sv
module spi_dma_req #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          multi,
  input  logic [CW-1:0] avail,
  input  logic [CW-1:0] trig,
  input  logic          clr,
  output logic          req
);
  import spi_fifo_pkg::*;

  dma_mode_e mode;
  logic      cond;
  logic      hold;

  assign mode = dma_mode_e'(multi);
  assign cond = (mode == DMA_MULTI) ? (avail >= trig) : (avail != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      req  <= 1'b0;
      hold <= 1'b0;
    end else begin
      hold <= clr;
      req  <= cond && !clr && !hold;
    end
  end

  AST_CLR_DROP: assert property (@(posedge clk) disable iff (rst)
    clr |=> !req); // R7
  AST_CLR_GAP: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |=> !req); // R7
endmodule

// File: rtl/spi_fifo_dma.sv
module spi_fifo_dma #(
  parameter int unsigned DEPTH = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cpu_wr_en,
  input  logic [7:0]                  cpu_wr_data,
  output logic [$clog2(DEPTH):0]      tx_level,
  input  logic                        cpu_rd_en,
  output logic [7:0]                  cpu_rd_data,
  output logic                        cpu_rd_valid,
  output logic [$clog2(DEPTH):0]      rx_level,
  input  logic                        sh_load,
  output logic [7:0]                  sh_tx_data,
  output logic                        sh_tx_valid,
  input  logic                        sh_cap,
  input  logic [7:0]                  sh_cap_data,
  input  logic [$clog2(DEPTH):0]      trig_level,
  input  logic                        irq_en,
  input  logic                        dma_multi,
  input  logic                        ovr_clr,
  output logic                        ovr_flag,
  output logic                        irq,
  output logic                        tx_dma_req,
  input  logic                        tx_dma_clr,
  output logic                        rx_dma_req,
  input  logic                        rx_dma_clr
);
  import spi_fifo_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0] tx_free;
  logic          ovr_evt;

  spi_fifo_core #(.DW(BYTE_W), .DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst),
    .push(cpu_wr_en), .wdata(cpu_wr_data),
    .pop(sh_load), .rdata(sh_tx_data), .rvalid(sh_tx_valid),
    .count(tx_level), .full(tx_full), .empty(tx_empty)
  );

  spi_fifo_core #(.DW(BYTE_W), .DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst),
    .push(sh_cap), .wdata(sh_cap_data),
    .pop(cpu_rd_en), .rdata(cpu_rd_data), .rvalid(cpu_rd_valid),
    .count(rx_level), .full(rx_full), .empty(rx_empty)
  );

  assign tx_free = DEPTH_C - tx_level;
  assign ovr_evt = sh_cap && rx_full && !cpu_rd_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ovr_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (ovr_evt)      ovr_flag <= 1'b1;
      else if (ovr_clr) ovr_flag <= 1'b0;
      irq <= irq_en && (rx_level >= trig_level);
    end
  end

  spi_dma_req #(.CW(CW)) u_tx_req (
    .clk(clk), .rst(rst), .multi(dma_multi),
    .avail(tx_free), .trig(trig_level), .clr(tx_dma_clr), .req(tx_dma_req)
  );

  spi_dma_req #(.CW(CW)) u_rx_req (
    .clk(clk), .rst(rst), .multi(dma_multi),
    .avail(rx_level), .trig(trig_level), .clr(rx_dma_clr), .req(rx_dma_req)
  );

  AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
    sh_cap && rx_full && !cpu_rd_en |=> ovr_flag); // R3
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovr_flag && !ovr_clr |=> ovr_flag); // R3
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq); // R4
  AST_NO_EMPTY_FULL: assert property (@(posedge clk) disable iff (rst)
    !(tx_full && tx_empty) && !(rx_full && rx_empty)); // R1
endmodule

// File: tb/tb_spi_fifo_dma.sv
`timescale 1ns/100ps
module tb_spi_fifo_dma;
  localparam int D  = 16;
  localparam int CW = $clog2(D) + 1;

  logic clk = 1'b0;
  logic rst;
  logic cpu_wr_en, cpu_rd_en, sh_load, sh_cap;
  logic [7:0] cpu_wr_data, sh_cap_data;
  logic [CW-1:0] trig_level;
  logic irq_en, dma_multi, ovr_clr, tx_dma_clr, rx_dma_clr;
  logic [CW-1:0] tx_level, rx_level;
  logic [7:0] cpu_rd_data, sh_tx_data;
  logic cpu_rd_valid, sh_tx_valid, ovr_flag, irq, tx_dma_req, rx_dma_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  spi_fifo_dma #(.DEPTH(D)) dut (
    .clk(clk), .rst(rst),
    .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data), .tx_level(tx_level),
    .cpu_rd_en(cpu_rd_en), .cpu_rd_data(cpu_rd_data), .cpu_rd_valid(cpu_rd_valid),
    .rx_level(rx_level), .sh_load(sh_load), .sh_tx_data(sh_tx_data),
    .sh_tx_valid(sh_tx_valid), .sh_cap(sh_cap), .sh_cap_data(sh_cap_data),
    .trig_level(trig_level), .irq_en(irq_en), .dma_multi(dma_multi),
    .ovr_clr(ovr_clr), .ovr_flag(ovr_flag), .irq(irq),
    .tx_dma_req(tx_dma_req), .tx_dma_clr(tx_dma_clr),
    .rx_dma_req(rx_dma_req), .rx_dma_clr(rx_dma_clr)
  );

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock: inputs set before, sampled after the edge, strobes dropped
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cpu_wr_en = 0; cpu_rd_en = 0; sh_load = 0; sh_cap = 0;
    ovr_clr = 0; tx_dma_clr = 0; rx_dma_clr = 0;
  endtask

  task automatic t_reset();
    rst = 1; tick(); tick();
    chk("R9 tx_level", tx_level, 0);
    chk("R9 rx_level", rx_level, 0);
    chk("R9 outs", {irq, ovr_flag, tx_dma_req, rx_dma_req, sh_tx_valid, cpu_rd_valid}, 0);
    rst = 0; tick();
  endtask

  task automatic t_tx_full();
    for (int i = 0; i < D; i++) begin
      cpu_wr_en = 1; cpu_wr_data = 8'hA0 + 8'(i); tick();
    end
    chk("R1 tx_level full", tx_level, D);
    cpu_wr_en = 1; cpu_wr_data = 8'hEE; tick();
    chk("R2 write rejected", tx_level, D);
    chk("R5 tx req low when full", tx_dma_req, 0);
    sh_load = 1; tick();
    chk("R10 load valid", sh_tx_valid, 1);
    chk("R10 load data", sh_tx_data, 8'hA0);
    chk("R2 slot freed", tx_level, D - 1);
    cpu_wr_en = 1; cpu_wr_data = 8'h5E; tick();
    chk("R2 write after load", tx_level, D);
    for (int i = 1; i < D; i++) begin
      sh_load = 1; tick();
      chk("R1 tx order", sh_tx_data, 8'hA0 + i);
    end
    sh_load = 1; tick();
    chk("R2 last byte is later write", sh_tx_data, 8'h5E);
    sh_load = 1; tick();
    chk("R10 empty load no valid", sh_tx_valid, 0);
    chk("R8 empty load level", tx_level, 0);
    chk("R5 tx req not full", tx_dma_req, 1);
  endtask

  task automatic t_rx_ovr_irq();
    trig_level = 4; irq_en = 1;
    for (int i = 0; i < 4; i++) begin
      sh_cap = 1; sh_cap_data = 8'h10 + 8'(i); tick();
    end
    chk("R4 irq lags level", irq, 0);
    tick();
    chk("R4 irq at trigger", irq, 1);
    for (int i = 4; i < D; i++) begin
      sh_cap = 1; sh_cap_data = 8'h10 + 8'(i); tick();
    end
    chk("R3 no ovr yet", ovr_flag, 0);
    sh_cap = 1; sh_cap_data = 8'h99; tick();
    chk("R3 ovr set", ovr_flag, 1);
    chk("R3 level kept", rx_level, D);
    tick(); tick();
    chk("R3 ovr sticky", ovr_flag, 1);
    irq_en = 0; tick();
    chk("R4 irq disabled", irq, 0);
    for (int i = 0; i < D; i++) begin
      cpu_rd_en = 1; tick();
      chk("R10 rd valid", cpu_rd_valid, 1);
      chk("R3 stored bytes kept", cpu_rd_data, 8'h10 + i);
    end
    chk("R3 discarded byte absent", rx_level, 0);
    ovr_clr = 1; tick();
    chk("R3 ovr cleared", ovr_flag, 0);
  endtask

  task automatic t_simul();
    for (int i = 0; i < D; i++) begin
      sh_cap = 1; sh_cap_data = 8'h30 + 8'(i); tick();
    end
    sh_cap = 1; sh_cap_data = 8'h55; cpu_rd_en = 1; tick();
    chk("R8 full swap data", cpu_rd_data, 8'h30);
    chk("R8 full swap level", rx_level, D);
    chk("R8 full swap no ovr", ovr_flag, 0);
    for (int i = 1; i < D; i++) begin
      cpu_rd_en = 1; tick();
    end
    cpu_rd_en = 1; tick();
    chk("R8 swapped byte last", cpu_rd_data, 8'h55);
    sh_cap = 1; sh_cap_data = 8'h77; cpu_rd_en = 1; tick();
    chk("R8 empty swap no valid", cpu_rd_valid, 0);
    chk("R8 empty swap level", rx_level, 1);
    cpu_rd_en = 1; tick();
    chk("R8 empty swap byte kept", cpu_rd_data, 8'h77);
  endtask

  task automatic t_multi();
    dma_multi = 1; trig_level = 4; tick();
    chk("R6 tx req free>=trig", tx_dma_req, 1);
    chk("R6 rx req empty", rx_dma_req, 0);
    for (int i = 0; i < 3; i++) begin
      sh_cap = 1; sh_cap_data = 8'(i); tick();
    end
    tick();
    chk("R6 rx req below trig", rx_dma_req, 0);
    sh_cap = 1; tick(); tick();
    chk("R6 rx req at trig", rx_dma_req, 1);
    for (int i = 0; i < D - 3; i++) begin
      cpu_wr_en = 1; cpu_wr_data = 8'(i); tick();
    end
    tick();
    chk("R6 tx req free below trig", tx_dma_req, 0);
    sh_load = 1; tick(); tick();
    chk("R6 tx req free at trig", tx_dma_req, 1);
  endtask

  task automatic t_clear();
    dma_multi = 0; tick();
    chk("R5 rx req nonempty", rx_dma_req, 1);
    rx_dma_clr = 1; tick();
    chk("R7 req low after clr", rx_dma_req, 0);
    tick();
    chk("R7 req held low", rx_dma_req, 0);
    tick();
    chk("R7 req returns", rx_dma_req, 1);
    for (int i = 0; i < 4; i++) begin
      cpu_rd_en = 1; tick();
    end
    tick();
    chk("R5 rx req empty", rx_dma_req, 0);
  endtask

  initial begin
    rst = 1; cpu_wr_en = 0; cpu_rd_en = 0; sh_load = 0; sh_cap = 0;
    cpu_wr_data = 0; sh_cap_data = 0; trig_level = 4; irq_en = 0;
    dma_multi = 0; ovr_clr = 0; tx_dma_clr = 0; rx_dma_clr = 0;
    @(negedge clk);
    t_reset();
    t_tx_full();
    t_rx_ovr_irq();
    t_simul();
    t_multi();
    t_clear();
    finish_run();
  end
endmodule